// File: doc/BRIEF.md
# Posted Write Buffer with Fault Capture

This block sits between a processor core and the external bus controller and holds one data write at a time. The core hands a write over through a valid/ready port, together with the program counter of the instruction that follows the store. The write counts as complete for the core once the buffer takes it. The buffer then runs the bus cycle on its own, presenting a request with the write's address, data and size until the bus answers with an acknowledge or a fault.

When the bus faults a write, the buffer copies that write and its follow-on program counter into a capture register. It raises a one-cycle fault pulse to the core and parks. Fault-handling code reads the captured fields from dedicated outputs and saves them. On resume the buffer issues the captured write again before it accepts anything new from the core. Any load whose data fed that write is therefore never run a second time. A fault on the replayed write sets a sticky double-fault flag, pulses again and parks once more.

Top module: `posted_wr_buf`

## Requirements
- R1: While reset is asserted and in the first cycle after it, wr_ready is 1, and bus_req, fault_pulse and double_fault are 0. fault_addr, fault_data, fault_size and fault_pc are all 0.
- R2: A write is taken on a rising edge where wr_valid and wr_ready are both 1. From the next cycle bus_req is 1, with bus_addr, bus_data and bus_size equal to the accepted wr_addr, wr_data and wr_size, and these hold steady until a cycle with bus_ack or bus_fault.
- R3: At most one write is outstanding. wr_ready is 0 from the acceptance edge until the edge where that write's bus cycle ends with an acknowledge, including all the time a fault is pending. A write offered while wr_ready is 0 is not taken and never reaches the bus.
- R4: An edge with bus_req, bus_ack = 1 and bus_fault = 0 ends the bus cycle. In the next cycle bus_req is 0 and wr_ready is 1.
- R5: An edge with bus_req and bus_fault = 1 on a first-issue write loads fault_addr, fault_data and fault_size from that write, and loads fault_pc from the next_pc sampled when the write was accepted. fault_pulse is 1 for exactly the following cycle, with the captured values already visible in that cycle.
- R6: When bus_fault and bus_ack are both 1 in the same cycle, the cycle is treated as a fault.
- R7: After a fault, bus_req stays 0, wr_ready stays 0 and the captured outputs stay unchanged until resume is sampled at 1.
- R8: resume sampled at 1 while a fault is parked makes bus_req rise in the next cycle, carrying exactly the captured address, data and size. The core is held until that replay is acknowledged. resume at any other time has no effect.
- R9: A fault on a replayed write sets double_fault, which then stays 1 until reset. It also pulses fault_pulse for one cycle, leaves the captured values unchanged, and parks the buffer again to wait for resume.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_valid | input | 1 | Core offers a write |
| wr_ready | output | 1 | Buffer is empty and takes the offered write |
| wr_addr | input | AW (32) | Write address |
| wr_data | input | DW (32) | Write data |
| wr_size | input | SW (2) | Write size code, carried through unchanged |
| next_pc | input | PW (32) | Program counter of the instruction after the store |
| resume | input | 1 | Replay the captured write |
| bus_req | output | 1 | Bus write cycle requested |
| bus_addr | output | AW (32) | Address of the requested write |
| bus_data | output | DW (32) | Data of the requested write |
| bus_size | output | SW (2) | Size code of the requested write |
| bus_ack | input | 1 | Bus cycle completed without error |
| bus_fault | input | 1 | Bus cycle ended in a fault |
| fault_pulse | output | 1 | One-cycle pulse after a fault was captured |
| fault_addr | output | AW (32) | Captured write address |
| fault_data | output | DW (32) | Captured write data |
| fault_size | output | SW (2) | Captured write size code |
| fault_pc | output | PW (32) | Captured next-instruction program counter |
| double_fault | output | 1 | Sticky flag: a replayed write faulted |

## Verification
Each result has a fixed latency. bus_req and its fields appear one cycle after the accepting edge. wr_ready returns one cycle after the acknowledging edge. fault_pulse and the captured fields appear one cycle after the faulting edge, and the replay request one cycle after the resume edge. The bench drives every input just after a rising edge and samples on the falling edge. Its bus model reacts in the same falling-edge slot where it compares, so each comparison falls in the exact cycle the latency predicts. A queue holds the writes the bench expects on the bus: a fault leaves the head entry in place so that the replay must match it, and only an acknowledge removes it. The expected state of wr_ready is checked against that queue's occupancy in every cycle.

// File: rtl/wpb_pkg.sv
package wpb_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_BUSY   = 2'd1,
        ST_HOLD   = 2'd2,
        ST_REPLAY = 2'd3
    } wpb_state_e;

endpackage

// File: rtl/wpb_slot.sv
// One write record (address, data, size, pc) with a load enable.
module wpb_slot #(
    parameter int AW = 32,
    parameter int DW = 32,
    parameter int SW = 2,
    parameter int PW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [AW-1:0] addr_i,
    input  logic [DW-1:0] data_i,
    input  logic [SW-1:0] size_i,
    input  logic [PW-1:0] pc_i,
    output logic [AW-1:0] addr_o,
    output logic [DW-1:0] data_o,
    output logic [SW-1:0] size_o,
    output logic [PW-1:0] pc_o
);
    typedef struct packed {
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
        logic [SW-1:0] size;
        logic [PW-1:0] pc;
    } rec_t;

    rec_t rec_d, rec_q;

    always_comb begin
        rec_d = rec_q;
        if (load_i) begin
            rec_d.addr = addr_i;
            rec_d.data = data_i;
            rec_d.size = size_i;
            rec_d.pc   = pc_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rec_q <= '0;
        else        rec_q <= rec_d;
    end

    assign addr_o = rec_q.addr;
    assign data_o = rec_q.data;
    assign size_o = rec_q.size;
    assign pc_o   = rec_q.pc;
endmodule

// File: rtl/wpb_ctrl.sv
// Sequencing of accept, bus cycle, fault park and replay.
module wpb_ctrl
    import wpb_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wr_valid_i,
    input  logic resume_i,
    input  logic bus_ack_i,
    input  logic bus_fault_i,
    output logic accept_o,
    output logic capture_o,
    output logic ready_o,
    output logic req_o,
    output logic replay_o,
    output logic pulse_o,
    output logic dbl_o
);
    typedef struct packed {
        wpb_state_e st;
        logic       pulse;
        logic       dbl;
    } ctrl_t;

    ctrl_t ctl_d, ctl_q;

    always_comb begin
        ctl_d       = ctl_q;
        ctl_d.pulse = 1'b0;
        accept_o    = 1'b0;
        capture_o   = 1'b0;
        unique case (ctl_q.st)
            ST_IDLE: begin
                if (wr_valid_i) begin
                    accept_o = 1'b1;
                    ctl_d.st = ST_BUSY;
                end
            end
            ST_BUSY: begin
                // fault outranks a simultaneous acknowledge
                if (bus_fault_i) begin
                    capture_o   = 1'b1;
                    ctl_d.pulse = 1'b1;
                    ctl_d.st    = ST_HOLD;
                end else if (bus_ack_i) begin
                    ctl_d.st = ST_IDLE;
                end
            end
            ST_HOLD: begin
                if (resume_i) ctl_d.st = ST_REPLAY;
            end
            ST_REPLAY: begin
                if (bus_fault_i) begin
                    ctl_d.pulse = 1'b1;
                    ctl_d.dbl   = 1'b1;
                    ctl_d.st    = ST_HOLD;
                end else if (bus_ack_i) begin
                    ctl_d.st = ST_IDLE;
                end
            end
            default: ctl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '{st: ST_IDLE, pulse: 1'b0, dbl: 1'b0};
        else        ctl_q <= ctl_d;
    end

    assign ready_o  = (ctl_q.st == ST_IDLE);
    assign req_o    = (ctl_q.st == ST_BUSY) || (ctl_q.st == ST_REPLAY);
    assign replay_o = (ctl_q.st == ST_REPLAY);
    assign pulse_o  = ctl_q.pulse;
    assign dbl_o    = ctl_q.dbl;
endmodule

// File: rtl/wpb_busmux.sv
// Chooses the record that drives the bus: first issue or replay.
module wpb_busmux #(
    parameter int AW = 32,
    parameter int DW = 32,
    parameter int SW = 2
) (
    input  logic          replay_i,
    input  logic [AW-1:0] pri_addr_i,
    input  logic [DW-1:0] pri_data_i,
    input  logic [SW-1:0] pri_size_i,
    input  logic [AW-1:0] cap_addr_i,
    input  logic [DW-1:0] cap_data_i,
    input  logic [SW-1:0] cap_size_i,
    output logic [AW-1:0] addr_o,
    output logic [DW-1:0] data_o,
    output logic [SW-1:0] size_o
);
    always_comb begin
        if (replay_i) begin
            addr_o = cap_addr_i;
            data_o = cap_data_i;
            size_o = cap_size_i;
        end else begin
            addr_o = pri_addr_i;
            data_o = pri_data_i;
            size_o = pri_size_i;
        end
    end
endmodule

// File: rtl/posted_wr_buf.sv
module posted_wr_buf #(
    parameter int AW = 32,
    parameter int DW = 32,
    parameter int SW = 2,
    parameter int PW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_valid,
    output logic          wr_ready,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [SW-1:0] wr_size,
    input  logic [PW-1:0] next_pc,
    input  logic          resume,
    output logic          bus_req,
    output logic [AW-1:0] bus_addr,
    output logic [DW-1:0] bus_data,
    output logic [SW-1:0] bus_size,
    input  logic          bus_ack,
    input  logic          bus_fault,
    output logic          fault_pulse,
    output logic [AW-1:0] fault_addr,
    output logic [DW-1:0] fault_data,
    output logic [SW-1:0] fault_size,
    output logic [PW-1:0] fault_pc,
    output logic          double_fault
);
    logic          accept, capture, replay;
    logic [AW-1:0] ent_addr;
    logic [DW-1:0] ent_data;
    logic [SW-1:0] ent_size;
    logic [PW-1:0] ent_pc;

    wpb_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_valid_i (wr_valid),
        .resume_i   (resume),
        .bus_ack_i  (bus_ack),
        .bus_fault_i(bus_fault),
        .accept_o   (accept),
        .capture_o  (capture),
        .ready_o    (wr_ready),
        .req_o      (bus_req),
        .replay_o   (replay),
        .pulse_o    (fault_pulse),
        .dbl_o      (double_fault)
    );

    // posted entry: loaded when the core hands a write over
    wpb_slot #(.AW(AW), .DW(DW), .SW(SW), .PW(PW)) u_entry (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (accept),
        .addr_i (wr_addr),
        .data_i (wr_data),
        .size_i (wr_size),
        .pc_i   (next_pc),
        .addr_o (ent_addr),
        .data_o (ent_data),
        .size_o (ent_size),
        .pc_o   (ent_pc)
    );

    // capture record: loaded from the entry on a first-issue fault
    wpb_slot #(.AW(AW), .DW(DW), .SW(SW), .PW(PW)) u_capture (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (capture),
        .addr_i (ent_addr),
        .data_i (ent_data),
        .size_i (ent_size),
        .pc_i   (ent_pc),
        .addr_o (fault_addr),
        .data_o (fault_data),
        .size_o (fault_size),
        .pc_o   (fault_pc)
    );

    wpb_busmux #(.AW(AW), .DW(DW), .SW(SW)) u_mux (
        .replay_i   (replay),
        .pri_addr_i (ent_addr),
        .pri_data_i (ent_data),
        .pri_size_i (ent_size),
        .cap_addr_i (fault_addr),
        .cap_data_i (fault_data),
        .cap_size_i (fault_size),
        .addr_o     (bus_addr),
        .data_o     (bus_data),
        .size_o     (bus_size)
    );
endmodule

// File: rtl/wpb_checker.sv
module wpb_checker #(
    parameter int AW = 32,
    parameter int DW = 32,
    parameter int SW = 2,
    parameter int PW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          wr_valid,
    input logic          wr_ready,
    input logic          resume,
    input logic          bus_req,
    input logic [AW-1:0] bus_addr,
    input logic [DW-1:0] bus_data,
    input logic [SW-1:0] bus_size,
    input logic          bus_ack,
    input logic          bus_fault,
    input logic          fault_pulse,
    input logic [AW-1:0] fault_addr,
    input logic [DW-1:0] fault_data,
    input logic [PW-1:0] fault_pc,
    input logic          double_fault
);
    p_accept_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid && wr_ready |=> bus_req);

    p_req_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && !bus_ack && !bus_fault |=>
            bus_req && $stable(bus_addr) && $stable(bus_data) && $stable(bus_size));

    p_one_pending_r3: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req |-> !wr_ready);

    p_ack_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && bus_ack && !bus_fault |=> !bus_req && wr_ready);

    p_fault_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && bus_fault |=> fault_pulse && !bus_req && !wr_ready);

    p_pulse_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        fault_pulse |=> !fault_pulse);

    p_capture_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_req && bus_fault) |=>
            $stable(fault_addr) && $stable(fault_data) && $stable(fault_pc));

    p_resume_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        resume && wr_ready && !wr_valid |=> !bus_req);

    p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        double_fault |=> double_fault);
endmodule

bind posted_wr_buf wpb_checker #(.AW(AW), .DW(DW), .SW(SW), .PW(PW)) u_wpb_chk (.*);

// File: tb/test_posted_wr_buf.sv
`timescale 1ns/1ps
module test_posted_wr_buf;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_valid = 1'b0;
    logic        wr_ready;
    logic [31:0] wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [1:0]  wr_size = '0;
    logic [31:0] next_pc = '0;
    logic        resume = 1'b0;
    logic        bus_req;
    logic [31:0] bus_addr;
    logic [31:0] bus_data;
    logic [1:0]  bus_size;
    logic        bus_ack = 1'b0;
    logic        bus_fault = 1'b0;
    logic        fault_pulse;
    logic [31:0] fault_addr;
    logic [31:0] fault_data;
    logic [1:0]  fault_size;
    logic [31:0] fault_pc;
    logic        double_fault;

    always #2.5 clk = ~clk;

    posted_wr_buf i_posted_wr_buf (.*);

    typedef struct {
        logic [31:0] a;
        logic [31:0] d;
        logic [1:0]  s;
        logic [31:0] pc;
        int          nfault;
    } item_t;

    item_t exp_q[$];
    item_t last_f;
    int    n_checks = 0;
    int    n_fail   = 0;
    int    inject   = 0;
    bit    both     = 0;
    int    bus_wait = 0;
    int    waitc    = 0;
    bit    pulse_due = 0;
    bit    dbl_due   = 0;
    bit    holding   = 0;
    bit    done      = 0;

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic do_write(input logic [31:0] a, input logic [31:0] d, input logic [1:0] s, input logic [31:0] pc);
        item_t it;
        @(posedge clk); #1;
        wr_valid = 1'b1; wr_addr = a; wr_data = d; wr_size = s; next_pc = pc;
        @(negedge clk);
        while (!wr_ready) @(negedge clk);
        @(posedge clk); #1;
        wr_valid = 1'b0;
        it.a = a; it.d = d; it.s = s; it.pc = pc; it.nfault = 0;
        exp_q.push_back(it);
    endtask

    task automatic do_resume();
        @(posedge clk); #1;
        resume = 1'b1; holding = 1'b0;
        @(posedge clk); #1;
        resume = 1'b0;
    endtask

    task automatic wait_hold();
        while (!holding) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic wait_empty();
        while (exp_q.size() != 0) @(negedge clk);
        @(negedge clk);
    endtask

    // scoreboard monitor and bus responder
    initial begin
        forever begin
            @(negedge clk);
            if (!rst_n) begin
                bus_ack = 0; bus_fault = 0; pulse_due = 0;
                continue;
            end
            check(fault_pulse == pulse_due, "R5 fault_pulse timing", 64'(fault_pulse), 64'(pulse_due));
            if (pulse_due) begin
                check(fault_addr == last_f.a, "R5 fault_addr", 64'(fault_addr), 64'(last_f.a));
                check(fault_data == last_f.d, "R5 fault_data", 64'(fault_data), 64'(last_f.d));
                check(fault_size == last_f.s, "R5 fault_size", 64'(fault_size), 64'(last_f.s));
                check(fault_pc == last_f.pc, "R5 fault_pc", 64'(fault_pc), 64'(last_f.pc));
                check(double_fault == dbl_due || (double_fault && !dbl_due && last_f.nfault == 1 && 0),
                      "R9 double_fault", 64'(double_fault), 64'(dbl_due));
            end
            pulse_due = 0;
            check(wr_ready == (exp_q.size() == 0), "R3 wr_ready vs outstanding", 64'(wr_ready), 64'(exp_q.size() == 0));
            if (holding)
                check(!bus_req, "R7 no request while parked", 64'(bus_req), 64'd0);
            bus_ack = 0; bus_fault = 0;
            if (bus_req && !holding) begin
                if (exp_q.size() == 0) begin
                    check(0, "R8 unexpected bus request", 64'(bus_addr), 64'd0);
                end else begin
                    check(bus_addr == exp_q[0].a, "R2 bus_addr", 64'(bus_addr), 64'(exp_q[0].a));
                    check(bus_data == exp_q[0].d, "R2 bus_data", 64'(bus_data), 64'(exp_q[0].d));
                    check(bus_size == exp_q[0].s, "R2 bus_size", 64'(bus_size), 64'(exp_q[0].s));
                    if (waitc < bus_wait) begin
                        waitc++;
                    end else begin
                        waitc = 0;
                        if (inject > 0) begin
                            inject--;
                            bus_fault = 1;
                            bus_ack = both;
                            exp_q[0].nfault++;
                            if (exp_q[0].nfault == 1) last_f = exp_q[0];
                            dbl_due = dbl_due || (exp_q[0].nfault >= 2);
                            pulse_due = 1;
                            holding = 1;
                        end else begin
                            bus_ack = 1;
                            void'(exp_q.pop_front());
                        end
                    end
                end
            end
        end
    end

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (2) @(negedge clk);
        // R1 during reset
        check(wr_ready == 1, "R1 wr_ready in reset", 64'(wr_ready), 64'd1);
        check(bus_req == 0 && fault_pulse == 0 && double_fault == 0, "R1 flags in reset",
              64'({bus_req, fault_pulse, double_fault}), 64'd0);
        repeat (2) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        check(wr_ready == 1 && bus_req == 0, "R1 after release", 64'({wr_ready, bus_req}), 64'b10);
        check({fault_addr, fault_data} == '0 && fault_size == 0 && fault_pc == 0, "R1 capture zero",
              64'(fault_addr ^ fault_data ^ fault_pc), 64'd0);

        // R2 R4: clean writes, back to back and with bus wait states
        do_write(32'h1000_0000, 32'hDEAD_BEEF, 2'd2, 32'h0000_0104);
        do_write(32'h1000_0004, 32'h0000_00A5, 2'd0, 32'h0000_0108);
        wait_empty();
        bus_wait = 3;
        do_write(32'h2000_0010, 32'h1234_5678, 2'd1, 32'h0000_0200);
        wait_empty();
        bus_wait = 0;

        // R5 R7 R3 R8: single fault, ignored write while parked, resume and replay
        inject = 1;
        do_write(32'h3000_0020, 32'hCAFE_F00D, 2'd2, 32'h0000_0300);
        wait_hold();
        @(posedge clk); #1;
        wr_valid = 1'b1; wr_addr = 32'h5555_5555; wr_data = 32'h6666_6666; wr_size = 2'd3; next_pc = 32'h7777_7777;
        repeat (3) @(posedge clk);
        #1 wr_valid = 1'b0;
        @(negedge clk);
        check(fault_addr == 32'h3000_0020 && fault_pc == 32'h0000_0300, "R3 R7 capture unchanged by blocked write",
              64'(fault_addr), 64'h3000_0020);
        check(bus_req == 0 && wr_ready == 0, "R7 parked outputs", 64'({bus_req, wr_ready}), 64'd0);
        check(double_fault == 0, "R9 no double after single fault", 64'(double_fault), 64'd0);
        do_resume();
        @(negedge clk);
        check(bus_req == 1 && bus_data == 32'hCAFE_F00D, "R8 replay carries captured write",
              64'(bus_data), 64'hCAFE_F00D);
        wait_empty();
        check(wr_ready == 1, "R8 core released after replay ack", 64'(wr_ready), 64'd1);

        // R8: resume while idle is ignored
        @(posedge clk); #1 resume = 1'b1;
        @(posedge clk); #1 resume = 1'b0;
        @(negedge clk);
        check(bus_req == 0 && wr_ready == 1, "R8 resume ignored when idle", 64'({bus_req, wr_ready}), 64'b01);

        // R6: fault and ack together count as fault
        inject = 1; both = 1;
        do_write(32'h4000_0040, 32'h0BAD_0BAD, 2'd1, 32'h0000_0404);
        wait_hold();
        both = 0;
        check(bus_req == 0 && wr_ready == 0, "R6 fault wins over ack", 64'({bus_req, wr_ready}), 64'd0);
        do_resume();
        wait_empty();

        // R9: fault on replay, sticky double fault
        inject = 2;
        do_write(32'h5000_0050, 32'hFEED_FACE, 2'd3, 32'h0000_0504);
        wait_hold();
        do_resume();
        wait_hold();
        check(double_fault == 1, "R9 double_fault set", 64'(double_fault), 64'd1);
        check(fault_addr == 32'h5000_0050 && fault_pc == 32'h0000_0504, "R9 capture kept",
              64'(fault_addr), 64'h5000_0050);
        do_resume();
        wait_empty();
        do_write(32'h6000_0060, 32'h0000_0001, 2'd0, 32'h0000_0604);
        wait_empty();
        check(double_fault == 1, "R9 double_fault sticky", 64'(double_fault), 64'd1);
        check(wr_ready == 1 && bus_req == 0, "R4 idle at end", 64'({wr_ready, bus_req}), 64'b10);

        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule